// File: doc/BRIEF.md
# Keypad Wake-Up Interrupt Combiner

This block gathers eight general-purpose input lines, such as keypad rows and columns, into one external interrupt request. It also gives a wake-up indication that a power-manager can use while the processor clock is stopped. Every line first passes through a two-stage synchronizer. The four low-order lines count as sources when they are driven low. Each of the four high-order lines counts as a source when it equals its own software-programmed expected level. Each line is admitted only when its bit in a gate-enable mask is set.

A configuration write loads the gate mask, the four expected levels and a trigger-mode bit in one cycle. In level mode the request flag follows the combined qualified request on every clock. In edge mode a 0-to-1 transition of the combined request sets the flag. The flag then holds until the vector acknowledge pulse or a software clear removes it. Software can also raise the flag directly. The wake output is derived combinationally from the synchronized, qualified lines, with no further register in its path.

Top module: `kpd_wake_gate`

## Requirements
- R1: Line i for i in 0..3 is a qualified source exactly when line i is 0 and gate-enable bit i is 1.
- R2: Line i for i in 4..7 is a qualified source exactly when line i equals expected-level bit i-4 and gate-enable bit i is 1. Otherwise it is not a source.
- R3: The combined request is the OR of all eight qualified sources. A single source on any line is sufficient.
- R4: With the mode bit at 0 (level mode), `irq_o` is 1 while any qualified source is present and returns to 0 once none remains.
- R5: With the mode bit at 1 (edge mode), a 0-to-1 change of the combined request sets `irq_o`. It stays set after the source goes away and is cleared by a one-cycle `vec_ack_i`. A source that stays present does not set it again after the clear.
- R6: In edge mode, when a hardware set and `vec_ack_i` occur in the same cycle, the set wins and `irq_o` stays 1.
- R7: A `sw_set_i` pulse sets `irq_o` on the next clock in either mode. In edge mode a `sw_clr_i` pulse clears it. In level mode a software set lasts one cycle unless a source is present.
- R8: After reset the gate mask, the expected levels and the mode are 0, and `irq_o` and `wake_o` are 0 whatever the lines show.
- R9: `wake_o` is 1 exactly when the synchronized lines give a qualified source. It does not depend on the flag, so it stays 1 after an acknowledge while the source is held.
- R10: A line change reaches `wake_o` after two rising clock edges and `irq_o` after three. A configuration write takes effect on qualification from the edge that loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 8 | Raw input lines |
| cfg_we_i | input | 1 | Load gate mask, levels and mode this cycle |
| cfg_gate_i | input | 8 | Gate-enable mask, one bit per line |
| cfg_lvl_i | input | 4 | Expected level for lines 4..7 (bit 0 for line 4) |
| cfg_edge_i | input | 1 | Mode: 0 level, 1 edge |
| sw_set_i | input | 1 | Software set of the request flag |
| sw_clr_i | input | 1 | Software clear of the request flag |
| vec_ack_i | input | 1 | Vector acknowledge pulse |
| irq_o | output | 1 | External interrupt request (the flag) |
| wake_o | output | 1 | Wake-up indication from the qualified lines |

## Verification
A wrong gate bit or a polarity error on a line appears on `wake_o` two edges after the line changes, and on `irq_o` one edge after that. A stuck or missed edge-mode flag appears as an `irq_o` that fails to rise, fails to hold after the source goes away, or survives an acknowledge. Each of these is visible on the first clock after the event that should have caused the change. An acknowledge that wrongly overrides a simultaneous set leaves `irq_o` at 0 on the very next sample.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
  typedef enum logic {
    KWG_LEVEL = 1'b0,
    KWG_EDGE  = 1'b1
  } kwg_mode_e;
endpackage

// File: rtl/kwg_sync.sv
module kwg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/kwg_qualify.sv
module kwg_qualify #(
  parameter int NLINES = 8,
  parameter int NLOW   = 4,
  localparam int NHIGH = NLINES - NLOW
) (
  input  logic [NLINES-1:0] line_i,
  input  logic [NLINES-1:0] gate_i,
  input  logic [NHIGH-1:0]  lvl_i,
  output logic [NLINES-1:0] hit_o,
  output logic              any_o
);
  // Active-low source test for the fixed-polarity lines
  function automatic logic low_hit(input logic l, input logic g);
    return g & ~l;
  endfunction

  // Match test for the programmable-level lines
  function automatic logic match_hit(input logic l, input logic e, input logic g);
    return g & (l ~^ e);
  endfunction

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i < NLOW) begin : g_low
      assign hit_o[i] = low_hit(line_i[i], gate_i[i]);
    end else begin : g_match
      assign hit_o[i] = match_hit(line_i[i], lvl_i[i-NLOW], gate_i[i]);
    end
  end

  assign any_o = |hit_o;

  // R1/R2: a masked-off line never yields a source
  always_comb begin
    p_gate_blocks_r1: assert (((hit_o & ~gate_i) == '0));
  end
endmodule

// File: rtl/kwg_flag.sv
module kwg_flag
  import kwg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  kwg_mode_e mode_i,
  input  logic      req_i,
  input  logic      sw_set_i,
  input  logic      sw_clr_i,
  input  logic      ack_i,
  output logic      rise_o,
  output logic      flag_o
);
  logic req_q;
  logic flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign rise_o = req_i & ~req_q;

  always_comb begin
    if (mode_i == KWG_EDGE)
      flag_d = rise_o | sw_set_i | (flag_o & ~ack_i & ~sw_clr_i);
    else
      flag_d = req_i | sw_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end

  // R5/R6: an edge-mode rise always lands in the flag, acknowledge or not
  p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == KWG_EDGE && rise_o) |=> flag_o);

  // R5: acknowledge without a competing set clears the flag
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == KWG_EDGE && ack_i && !rise_o && !sw_set_i) |=> !flag_o);

  // R7: software clear in edge mode
  p_sw_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == KWG_EDGE && sw_clr_i && !rise_o && !sw_set_i) |=> !flag_o);

  // R7: software set wins in either mode
  p_sw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_i |=> flag_o);

  // R4: level mode tracks the request
  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == KWG_LEVEL && !sw_set_i) |=> (flag_o == $past(req_i)));

  // R5: an edge-mode flag only appears with a cause
  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_o) && $past(mode_i) == KWG_EDGE) |-> $past(rise_o || sw_set_i));
endmodule

// File: rtl/kpd_wake_gate.sv
module kpd_wake_gate
  import kwg_pkg::*;
#(
  parameter int NLINES  = 8,
  parameter int NLOW    = 4,
  parameter int NSTAGES = 2,
  localparam int NHIGH  = NLINES - NLOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_i,
  input  logic              cfg_we_i,
  input  logic [NLINES-1:0] cfg_gate_i,
  input  logic [NHIGH-1:0]  cfg_lvl_i,
  input  logic              cfg_edge_i,
  input  logic              sw_set_i,
  input  logic              sw_clr_i,
  input  logic              vec_ack_i,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NLINES-1:0] gate_q;
  logic [NHIGH-1:0]  lvl_q;
  kwg_mode_e         mode_q;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] src_hit;
  logic              req_any;
  logic              req_rise;
  logic              flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      lvl_q  <= '0;
      mode_q <= KWG_LEVEL;
    end else if (cfg_we_i) begin
      gate_q <= cfg_gate_i;
      lvl_q  <= cfg_lvl_i;
      mode_q <= kwg_mode_e'(cfg_edge_i);
    end
  end

  kwg_sync #(.W(NLINES), .STAGES(NSTAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (line_i),
    .q_o  (line_s)
  );

  kwg_qualify #(.NLINES(NLINES), .NLOW(NLOW)) qual_i (
    .line_i(line_s),
    .gate_i(gate_q),
    .lvl_i (lvl_q),
    .hit_o (src_hit),
    .any_o (req_any)
  );

  kwg_flag flag_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_q),
    .req_i   (req_any),
    .sw_set_i(sw_set_i),
    .sw_clr_i(sw_clr_i),
    .ack_i   (vec_ack_i),
    .rise_o  (req_rise),
    .flag_o  (flag_q)
  );

  assign irq_o  = flag_q;
  assign wake_o = req_any;

  // R9: wake is present whenever the flag was just raised by hardware
  p_rise_has_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |-> wake_o);

  // R4: in level mode a wake indication becomes a request one edge later
  p_wake_to_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == KWG_LEVEL && wake_o) |=> irq_o);
endmodule

// File: tb/kpd_wake_gate_tb_top.sv
module kpd_wake_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_i = 8'hFF;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_gate_i = '0;
  logic [3:0] cfg_lvl_i = '0;
  logic       cfg_edge_i = 1'b0;
  logic       sw_set_i = 1'b0;
  logic       sw_clr_i = 1'b0;
  logic       vec_ack_i = 1'b0;
  logic       irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  kpd_wake_gate dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .cfg_we_i(cfg_we_i),
    .cfg_gate_i(cfg_gate_i), .cfg_lvl_i(cfg_lvl_i), .cfg_edge_i(cfg_edge_i),
    .sw_set_i(sw_set_i), .sw_clr_i(sw_clr_i), .vec_ack_i(vec_ack_i),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  // {gate, level, lines, expected request}
  localparam logic [20:0] VEC [0:9] = '{
    {8'h01, 4'h0, 8'hFF, 1'b0},  // R1 line0 high
    {8'h01, 4'h0, 8'hFE, 1'b1},  // R1 line0 low
    {8'h00, 4'h0, 8'h00, 1'b0},  // R1/R2 everything masked
    {8'h10, 4'h1, 8'h10, 1'b1},  // R2 line4 matches 1
    {8'h10, 4'h0, 8'h10, 1'b0},  // R2 line4 mismatch
    {8'h10, 4'h0, 8'h00, 1'b1},  // R2 line4 matches 0
    {8'h80, 4'h8, 8'h80, 1'b1},  // R2 line7 matches
    {8'hF0, 4'h5, 8'hAF, 1'b0},  // R2/R3 all high lines mismatch
    {8'h0F, 4'h0, 8'hF7, 1'b1},  // R3 only line3
    {8'hFF, 4'hF, 8'hFF, 1'b1}   // R3 high lines all match
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] g, input logic [3:0] l, input logic m);
    cfg_gate_i = g; cfg_lvl_i = l; cfg_edge_i = m; cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_ack();
    vec_ack_i = 1'b1; @(negedge clk); vec_ack_i = 1'b0;
  endtask

  initial begin
    wait_n(3);
    line_i = 8'h00;
    wait_n(1);
    check("R8 reset irq", irq_o, 1'b0);
    check("R8 reset wake", wake_o, 1'b0);
    rst_n = 1'b1;
    wait_n(4);
    check("R8 unconfigured irq", irq_o, 1'b0);
    check("R8 unconfigured wake", wake_o, 1'b0);

    // level-mode table
    for (int v = 0; v < 10; v++) begin
      line_i = VEC[v][8:1];
      wr_cfg(VEC[v][20:13], VEC[v][12:9], 1'b0);
      wait_n(2);
      check("R4 table irq", irq_o, VEC[v][0]);
      check("R9 table wake", wake_o, VEC[v][0]);
    end

    // R10 latency: line change to wake after 2 edges, irq after 3
    wr_cfg(8'h01, 4'h0, 1'b0);
    line_i = 8'hFF; wait_n(4);
    line_i = 8'hFE;
    wait_n(1);
    check("R10 wake not after 1 edge", wake_o, 1'b0);
    wait_n(1);
    check("R10 wake after 2 edges", wake_o, 1'b1);
    check("R10 irq not after 2 edges", irq_o, 1'b0);
    wait_n(1);
    check("R10 irq after 3 edges", irq_o, 1'b1);
    line_i = 8'hFF; wait_n(3);
    check("R4 level release", irq_o, 1'b0);

    // R7 level-mode software set is one cycle
    sw_set_i = 1'b1; @(negedge clk); sw_set_i = 1'b0;
    check("R7 level sw set", irq_o, 1'b1);
    wait_n(1);
    check("R7 level sw set ends", irq_o, 1'b0);

    // edge mode
    wr_cfg(8'h01, 4'h0, 1'b1);
    wait_n(3);
    pulse_ack();
    check("R5 edge idle", irq_o, 1'b0);
    line_i = 8'hFE; wait_n(3);
    check("R5 edge set", irq_o, 1'b1);
    line_i = 8'hFF; wait_n(3);
    check("R5 edge held", irq_o, 1'b1);
    check("R9 wake follows source", wake_o, 1'b0);
    pulse_ack();
    check("R5 ack clears", irq_o, 1'b0);
    line_i = 8'hFE; wait_n(3);
    check("R5 second edge", irq_o, 1'b1);
    pulse_ack();
    check("R5 ack with held source", irq_o, 1'b0);
    wait_n(2);
    check("R5 held source no re-set", irq_o, 1'b0);
    check("R9 wake after ack", wake_o, 1'b1);

    // R6 set beats acknowledge
    line_i = 8'hFF; wait_n(3);
    line_i = 8'hFE; wait_n(2);
    pulse_ack();
    check("R6 set over ack", irq_o, 1'b1);
    pulse_ack();

    // R7 software set/clear in edge mode
    sw_set_i = 1'b1; @(negedge clk); sw_set_i = 1'b0;
    check("R7 edge sw set", irq_o, 1'b1);
    wait_n(2);
    check("R7 edge sw set holds", irq_o, 1'b1);
    sw_clr_i = 1'b1; @(negedge clk); sw_clr_i = 1'b0;
    check("R7 edge sw clr", irq_o, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule